// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns several reset causes into one clean reset condition, presented both as an active-high and an active-low output. The causes are a synchronous supply-low flag from an analog comparator, an active-low push-button input, an active-low reset line that something outside the block may pull low, and a watchdog. The watchdog expects activity on one monitored line. A parameter picks that line: either a dedicated kick pin or the serial data line of the board's two-wire bus. The watchdog counts any change of level, rising or falling, as activity.

Every timeout is counted in ticks. A prescaler divides the clock into ticks, and all tick counts are parameters. The defaults (1 ms tick, 200-tick reset stretch, 1600-tick watchdog, 10-tick debounce) match a 50 MHz clock. Simulation can scale them down. After power-on, and after every reset cause clears, the block keeps reset asserted for one full stretch timeout. The three asynchronous inputs pass through synchronizers first. The push-button input is then debounced.

Top module: `rst_supervisor`

## Requirements
- R1: While rst_ni is low, rst_o is 1 and rst_no is 0. Once rst_ni is released, the first clock edge is edge E. rst_o stays 1 through edge E+HOLD_TICKS-1 and is 0 after edge E+HOLD_TICKS (with TICK_DIV=1).
- R2: supply_low_i is used without a synchronizer. The edge that first samples it high sets rst_o. Let E be the first edge that samples it low again. rst_o is 1 through edge E+HOLD_TICKS-1 and 0 after edge E+HOLD_TICKS.
- R3: mr_ni is active low. It passes a 2-flop synchronizer and a debouncer, which take a new level only after DEB_TICKS consecutive ticks at that level. A low pulse shorter than DEB_TICKS ticks leaves rst_o at 0. A low of at least DEB_TICKS ticks raises rst_o DEB_TICKS+2 edges after the first sampling edge. After mr_ni returns high, release comes DEB_TICKS+2+HOLD_TICKS edges later.
- R4: rst_force_ni is active low and passes a 2-flop synchronizer. rst_o rises 2 edges after it goes low. rst_o is held while the line is low and falls 2+HOLD_TICKS edges after the first edge that samples it high.
- R5: If the synchronized monitored line shows no change for WDOG_TICKS ticks, the watchdog raises rst_o. The last change is sampled before edge E. rst_o is 0 after edge E+WDOG_TICKS+2 and 1 after edge E+WDOG_TICKS+3. The reset is then held for one full stretch timeout.
- R6: Any change of level on the monitored line restarts the watchdog count. A rising change and a falling change have the same effect.
- R7: WDOG_SRC=1 (serial line) monitors sda_i and ignores kick_i. WDOG_SRC=0 (kick pin) monitors kick_i and ignores sda_i.
- R8: The watchdog count is held at zero while rst_o is 1. It starts counting on release. With no activity, the next watchdog reset follows WDOG_TICKS+1 edges after the release edge.
- R9: rst_no is always the complement of rst_o.
- R10: A cause that asserts again during the stretch timeout restarts the full HOLD_TICKS timeout, counted from the moment it clears again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | Synchronous supply-below-threshold flag |
| mr_ni | input | 1 | Push-button reset, active low, asynchronous, bouncy |
| rst_force_ni | input | 1 | Externally forced reset line, active low, asynchronous |
| kick_i | input | 1 | Dedicated watchdog kick pin |
| sda_i | input | 1 | Serial data line, watched when WDOG_SRC=1 |
| rst_o | output | 1 | Reset, active high |
| rst_no | output | 1 | Reset, active low |

## Verification
The bench builds the block with TICK_DIV=1, HOLD_TICKS=20, WDOG_TICKS=60, DEB_TICKS=4 and WDOG_SRC=1. With one tick per clock, every latency named in the requirements is an exact edge count, so the bench checks each release on both sides of its edge. A full watchdog expiry, its stretch timeout and the following re-expiry all fit in a few hundred cycles. Because the serial line is the monitored input, toggling the kick pin during a watchdog wait shows that the unselected input is ignored.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum logic {
    WD_KICK_PIN    = 1'b0,
    WD_SERIAL_LINE = 1'b1
  } wd_src_e;
endpackage

// File: rtl/rsup_tick.sv
module rsup_tick #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == PW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '1;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
  parameter int DEB_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(DEB_TICKS - 1)) begin
        lvl_q <= d_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign q_o = lvl_q;

  AST_DEB_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> lvl_q == $past(d_i)); // R3
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
  parameter int WDOG_TICKS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mon_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam int CW = $clog2(WDOG_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          prev_q;
  logic          exp_q;
  logic          act;

  assign act = mon_i ^ prev_q;  // either polarity

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
      exp_q  <= 1'b0;
    end else begin
      prev_q <= mon_i;
      exp_q  <= 1'b0;
      if (hold_i || act) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CW'(WDOG_TICKS - 1)) begin
          cnt_q <= '0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign expire_o = exp_q;

  AST_WD_CLEAR_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_q == '0); // R8
  AST_WD_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |=> !exp_q); // R6
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int      TICK_DIV    = 50000,
  parameter int      HOLD_TICKS  = 200,
  parameter int      WDOG_TICKS  = 1600,
  parameter int      DEB_TICKS   = 10,
  parameter int      SYNC_STAGES = 2,
  parameter wd_src_e WDOG_SRC    = WD_SERIAL_LINE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_low_i,
  input  logic mr_ni,
  input  logic rst_force_ni,
  input  logic kick_i,
  input  logic sda_i,
  output logic rst_o,
  output logic rst_no
);
  localparam int HW      = $clog2(HOLD_TICKS + 1);
  localparam int N_ASYNC = 3;
  localparam int IX_MR   = 0;
  localparam int IX_FRC  = 1;
  localparam int IX_MON  = 2;

  logic               tick;
  logic               mon_raw;
  logic [N_ASYNC-1:0] raw, syn;
  logic               mr_deb;
  logic               wd_exp;
  logic               any_src;
  logic               rst_act;
  logic [HW-1:0]      hold_q;
  logic               rst_q, rst_nq;

  assign mon_raw = (WDOG_SRC == WD_SERIAL_LINE) ? sda_i : kick_i;
  assign raw     = {mon_raw, rst_force_ni, mr_ni};

  rsup_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    rsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .d_i(raw[g]), .q_o(syn[g])
    );
  end

  rsup_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk_i, .rst_ni, .tick_i(tick), .d_i(syn[IX_MR]), .q_o(mr_deb)
  );

  rsup_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
    .clk_i, .rst_ni, .tick_i(tick), .mon_i(syn[IX_MON]),
    .hold_i(rst_q), .expire_o(wd_exp)
  );

  assign any_src = supply_low_i | ~mr_deb | ~syn[IX_FRC] | wd_exp;
  assign rst_act = any_src | (hold_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= HW'(HOLD_TICKS);  // power-on stretch
      rst_q  <= 1'b1;
      rst_nq <= 1'b0;
    end else begin
      if (any_src)                    hold_q <= HW'(HOLD_TICKS);
      else if (tick && hold_q != '0)  hold_q <= hold_q - 1'b1;
      rst_q  <= rst_act;
      rst_nq <= ~rst_act;
    end
  end

  assign rst_o  = rst_q;
  assign rst_no = rst_nq;

  AST_SRC_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_src |=> rst_q); // R2
  AST_OUT_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q != rst_nq); // R9
  AST_RELEASE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> !$past(any_src)); // R10
endmodule

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;
  import rst_sup_pkg::*;

  localparam int HOLD = 20;
  localparam int WDOG = 60;
  localparam int DEB  = 4;

  logic clk = 1'b0;
  logic rst_ni, supply_low, mr_n, force_n, kick, sda;
  logic rst_o, rst_no;
  bit   kick_en = 1'b1;
  bit   done    = 1'b0;
  int   n_chk   = 0;
  int   n_bad   = 0;

  always #5 clk = ~clk;

  rst_supervisor #(
    .TICK_DIV(1), .HOLD_TICKS(HOLD), .WDOG_TICKS(WDOG),
    .DEB_TICKS(DEB), .SYNC_STAGES(2), .WDOG_SRC(WD_SERIAL_LINE)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low), .mr_ni(mr_n),
    .rst_force_ni(force_n), .kick_i(kick), .sda_i(sda),
    .rst_o(rst_o), .rst_no(rst_no)
  );

  // src 0: supply flag, 1: push button, 2: forced line
  function automatic int lat_of(int src);
    case (src)
      0:       return 0;
      1:       return DEB + 2;
      default: return 2;
    endcase
  endfunction

  function automatic string req_of(int src);
    case (src)
      0:       return "R2";
      1:       return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rst(bit exp, string req);
    n_chk++;
    if (rst_o !== exp || rst_no !== ~exp) begin
      n_bad++;
      $display("FAIL %s (R9 pair): rst_o=%b rst_no=%b expected rst_o=%b rst_no=%b",
               req, rst_o, rst_no, exp, ~exp);
    end
  endtask

  task automatic drive_src(int src, bit act);
    case (src)
      0:       supply_low = act;
      1:       mr_n       = ~act;
      default: force_n    = ~act;
    endcase
  endtask

  task automatic pulse(int src, int w);
    int lat = lat_of(src);
    drive_src(src, 1'b1);
    step(lat + 1);
    chk_rst(1'b1, {req_of(src), " assert"});
    step(w - lat - 1);
    drive_src(src, 1'b0);
    step(lat + HOLD);
    chk_rst(1'b1, {req_of(src), " stretch"});
    step(1);
    chk_rst(1'b0, {req_of(src), " release"});
  endtask

  initial begin : kicker
    forever begin
      step(16);
      if (kick_en) sda = ~sda;
    end
  end

  initial begin : hang_guard
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: bench hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0101));
    rst_ni = 1'b0; supply_low = 1'b0; mr_n = 1'b1; force_n = 1'b1;
    kick = 1'b0; sda = 1'b1;
    step(5);
    chk_rst(1'b1, "R1 in reset");
    rst_ni = 1'b1;
    step(HOLD);
    chk_rst(1'b1, "R1 power-on stretch");
    step(1);
    chk_rst(1'b0, "R1 power-on release");

    // directed: each source once
    for (int s = 0; s < 3; s++) pulse(s, lat_of(s) + 8);

    // R3: glitch shorter than debounce is ignored
    mr_n = 1'b0; step(DEB - 1); mr_n = 1'b1;
    for (int i = 0; i < DEB + HOLD + 5; i++) begin
      step(1);
      chk_rst(1'b0, "R3 glitch ignored");
    end

    // R3: low for exactly DEB ticks is accepted
    mr_n = 1'b0; step(DEB); mr_n = 1'b1;
    step(3);
    chk_rst(1'b1, "R3 boundary accept");
    step(DEB + HOLD - 1);
    chk_rst(1'b1, "R3 boundary stretch");
    step(1);
    chk_rst(1'b0, "R3 boundary release");

    // R10: retrigger during stretch restarts the full timeout
    supply_low = 1'b1; step(1); supply_low = 1'b0;
    step(10);
    supply_low = 1'b1; step(1); supply_low = 1'b0;
    step(HOLD - 10);
    chk_rst(1'b1, "R10 old release point");
    step(10);
    chk_rst(1'b1, "R10 restarted stretch");
    step(1);
    chk_rst(1'b0, "R10 release");

    // random mix of sources and widths
    for (int it = 0; it < 40; it++) begin
      int s = int'($urandom % 3);
      int w = lat_of(s) + 1 + int'($urandom % 25);
      step(int'($urandom % 4));
      pulse(s, w);
    end

    // R6: regular activity of both polarities keeps reset off
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (i % 10 == 0) chk_rst(1'b0, "R6 kicked");
    end

    // R5/R7: stop the serial line, toggle the unselected kick pin
    kick_en = 1'b0;
    step(1);
    sda = ~sda;
    for (int i = 0; i < WDOG + 3; i++) begin
      if (i % 5 == 0) kick = ~kick;
      step(1);
    end
    chk_rst(1'b0, "R7 kick pin ignored, R5 before expiry");
    step(1);
    chk_rst(1'b1, "R5 expiry");
    step(HOLD);
    chk_rst(1'b1, "R5 stretch");
    step(1);
    chk_rst(1'b0, "R5 release");

    // R8: count starts from release
    step(WDOG);
    chk_rst(1'b0, "R8 before re-expiry");
    step(1);
    chk_rst(1'b1, "R8 re-expiry");
    kick_en = 1'b1;
    step(HOLD + 1);
    chk_rst(1'b0, "R8 release");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule